// File: doc/BRIEF.md
# Ready-Gated System Clock Source Selector

This controller decides which of three oscillators feeds the system clock: the on-chip RC oscillator, the external crystal oscillator, or the PLL output. Software writes a 2-bit source code with a one-cycle strobe. The controller drives a one-hot select to the glitch-free clock multiplexer, which sits outside this block. It also presents a status word, with the code of the source in use placed two bits up.

A switch is made only when the chosen source reports ready. A request for a source that is not ready is remembered, and the switch happens on its own once the ready flag rises. Hardware can take the clock back to the internal oscillator in two cases. The first is a wake from a low-power state. The second is a loss of the external oscillator while clock security is enabled and that oscillator feeds the system clock, either directly or as the PLL reference. After such a failure the external oscillator cannot be chosen again until its failure flag drops. All ready and failure inputs are taken as already synchronous to `clk`.

Top module: `sysclk_source_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, the internal oscillator is in use: `mux_sel` = 3'b001, `status` = 0, and no request is pending.
- R2: Source codes on `req_code` are 2'b00 internal, 2'b01 external and 2'b10 PLL, accepted when `req_we` is high. `mux_sel` is one-hot, with bit 0 for internal, bit 1 for external and bit 2 for PLL.
- R3: A request for a source whose ready flag is high at the strobe edge takes effect at that edge, so `mux_sel` changes in the next cycle.
- R4: A request for a source that is not ready is held. The switch happens at the first clock edge where that source's ready flag is high. `mux_sel` never moves to the external oscillator or the PLL unless that source was ready at the switching edge.
- R5: A new valid request replaces a request that is still pending, and the earlier target is then never selected.
- R6: Requesting the source already in use cancels any pending request.
- R7: Code 2'b11 is ignored: the source in use and any pending request stay unchanged.
- R8: `status` carries the active source code at bits 3:2, with all other bits zero. It changes in the same cycle as `mux_sel`.
- R9: When `css_en` and `ext_fail` are both high at a clock edge and the system clock comes from the external oscillator, or from the PLL while `pll_ref_ext` is high, the internal oscillator is selected at that edge and any pending request is cleared. With `css_en` low, `ext_fail` has no effect.
- R10: After a forced fallback, a lockout holds until the first edge at which `ext_fail` is low. While it holds, requests for the external oscillator, and for the PLL while `pll_ref_ext` is high, are ignored.
- R11: A high `wake` at a clock edge selects the internal oscillator and clears any pending request. It overrides a request strobed in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_we | input | 1 | One-cycle strobe that writes a source request |
| req_code | input | 2 | Requested source code |
| rdy_int | input | 1 | Internal oscillator stable |
| rdy_ext | input | 1 | External oscillator stable |
| rdy_pll | input | 1 | PLL locked |
| pll_ref_ext | input | 1 | PLL reference is the external oscillator |
| css_en | input | 1 | Clock security enable |
| ext_fail | input | 1 | External oscillator failure detected |
| wake | input | 1 | Wake event from a low-power state |
| mux_sel | output | 3 | One-hot clock multiplexer select |
| status | output | STAT_W | Status word with the active source code at FIELD_LSB |

## Verification
The assertions assume that every ready, failure and wake input is sampled synchronously and is defined from the first clock edge. They also assume that nothing other than this controller moves the select. The ready checks therefore compare a change in `mux_sel` against the ready flag one cycle earlier. The stimulus changes inputs one time unit after each rising edge and lets ready flags and `pll_ref_ext` drift slowly. It raises `ext_fail` and `wake` only rarely, so that pending requests, lockouts and fallbacks overlap in many orders without the inputs ever changing at a sampling edge.

// File: rtl/sysclk_pkg.sv
package sysclk_pkg;

    localparam int SRC_W = 2;
    localparam int NSRC  = 3;
    localparam int NCODE = 1 << SRC_W;

    typedef enum logic [SRC_W-1:0] {
        SRC_INT  = 2'd0,
        SRC_EXT  = 2'd1,
        SRC_PLL  = 2'd2,
        SRC_NONE = 2'd3
    } src_e;

    typedef struct packed {
        src_e act;     // source driving the system clock
        logic pend_v;  // a request waits for its source
        src_e pend;    // the waiting target
        logic lock;    // external oscillator barred after failure
    } ctl_t;

    localparam ctl_t CTL_RESET = '{act: SRC_INT, pend_v: 1'b0, pend: SRC_INT, lock: 1'b0};

endpackage

// File: rtl/sysclk_guard.sv
module sysclk_guard
    import sysclk_pkg::*;
(
    input  src_e             act_q,
    input  logic             lock_q,
    input  logic             pll_ref_ext,
    input  logic             css_en,
    input  logic             ext_fail,
    output logic             force_fb,
    output logic             lock_d,
    output logic [NCODE-1:0] blocked
);
    logic uses_ext;

    always_comb begin
        uses_ext = (act_q == SRC_EXT) || ((act_q == SRC_PLL) && pll_ref_ext);
        force_fb = css_en && ext_fail && uses_ext;
        lock_d   = ext_fail && (lock_q || force_fb);
        blocked          = '0;
        blocked[SRC_EXT] = lock_q;
        blocked[SRC_PLL] = lock_q && pll_ref_ext;
        blocked[SRC_NONE] = 1'b1;   // reserved code never selectable
    end
endmodule

// File: rtl/sysclk_req_stage.sv
module sysclk_req_stage
    import sysclk_pkg::*;
(
    input  logic             req_we,
    input  logic [SRC_W-1:0] req_code,
    input  src_e             act_q,
    input  logic             pend_v_q,
    input  src_e             pend_q,
    input  logic [NCODE-1:0] blocked,
    output logic             pend_v_d,
    output src_e             pend_d
);
    src_e code;

    always_comb begin
        code     = src_e'(req_code);
        pend_v_d = pend_v_q;
        pend_d   = pend_q;
        if (req_we && !blocked[req_code]) begin
            if (code == act_q) begin
                pend_v_d = 1'b0;
            end else begin
                pend_v_d = 1'b1;
                pend_d   = code;
            end
        end
    end
endmodule

// File: rtl/sysclk_status_enc.sv
module sysclk_status_enc
    import sysclk_pkg::*;
#(
    parameter int STAT_W    = 4,
    parameter int FIELD_LSB = 2
) (
    input  src_e              act_q,
    output logic [NSRC-1:0]   mux_sel,
    output logic [STAT_W-1:0] status
);
    localparam int FIELD_MSB = FIELD_LSB + SRC_W - 1;

    for (genvar i = 0; i < NSRC; i++) begin : g_sel
        assign mux_sel[i] = (act_q == src_e'(i));
    end

    for (genvar b = 0; b < STAT_W; b++) begin : g_stat
        if (b >= FIELD_LSB && b <= FIELD_MSB) begin : g_field
            assign status[b] = act_q[b - FIELD_LSB];
        end else begin : g_zero
            assign status[b] = 1'b0;
        end
    end
endmodule

// File: rtl/sysclk_source_ctrl.sv
module sysclk_source_ctrl
    import sysclk_pkg::*;
#(
    parameter int STAT_W    = 4,
    parameter int FIELD_LSB = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_we,
    input  logic [1:0]        req_code,
    input  logic              rdy_int,
    input  logic              rdy_ext,
    input  logic              rdy_pll,
    input  logic              pll_ref_ext,
    input  logic              css_en,
    input  logic              ext_fail,
    input  logic              wake,
    output logic [2:0]        mux_sel,
    output logic [STAT_W-1:0] status
);
    ctl_t             ctl_q, ctl_d;
    logic             force_fb, lock_d, pend_v_n;
    logic [NCODE-1:0] blocked, ready_vec;
    src_e             pend_n;

    sysclk_guard u_guard (
        .act_q      (ctl_q.act),
        .lock_q     (ctl_q.lock),
        .pll_ref_ext(pll_ref_ext),
        .css_en     (css_en),
        .ext_fail   (ext_fail),
        .force_fb   (force_fb),
        .lock_d     (lock_d),
        .blocked    (blocked)
    );

    sysclk_req_stage u_req (
        .req_we   (req_we),
        .req_code (req_code),
        .act_q    (ctl_q.act),
        .pend_v_q (ctl_q.pend_v),
        .pend_q   (ctl_q.pend),
        .blocked  (blocked),
        .pend_v_d (pend_v_n),
        .pend_d   (pend_n)
    );

    assign ready_vec = {1'b0, rdy_pll, rdy_ext, rdy_int};

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.lock = lock_d;
        if (wake || force_fb) begin
            ctl_d.act    = SRC_INT;
            ctl_d.pend_v = 1'b0;
        end else begin
            ctl_d.pend_v = pend_v_n;
            ctl_d.pend   = pend_n;
            if (pend_v_n && ready_vec[pend_n] && !blocked[pend_n]) begin
                ctl_d.act    = pend_n;
                ctl_d.pend_v = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= CTL_RESET;
        else        ctl_q <= ctl_d;
    end

    sysclk_status_enc #(
        .STAT_W   (STAT_W),
        .FIELD_LSB(FIELD_LSB)
    ) u_enc (
        .act_q  (ctl_q.act),
        .mux_sel(mux_sel),
        .status (status)
    );
endmodule

// File: rtl/sysclk_source_ctrl_chk.sv
module sysclk_source_ctrl_chk #(
    parameter int STAT_W    = 4,
    parameter int FIELD_LSB = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rdy_ext,
    input logic              rdy_pll,
    input logic              pll_ref_ext,
    input logic              css_en,
    input logic              ext_fail,
    input logic              wake,
    input logic [2:0]        mux_sel,
    input logic [STAT_W-1:0] status
);
    localparam logic [STAT_W-1:0] FIELD_MASK = {{(STAT_W-2){1'b0}}, 2'b11} << FIELD_LSB;

    assert_reset_int_R1: assert property (@(posedge clk)
        !rst_n |=> (mux_sel == 3'b001));

    assert_onehot_sel_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(mux_sel) == 1);

    assert_status_match_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (((status & FIELD_MASK) >> FIELD_LSB) == {{(STAT_W-2){1'b0}}, mux_sel[2], mux_sel[1]})
        && ((status & ~FIELD_MASK) == '0));

    assert_ext_ready_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mux_sel == 3'b010 && $past(mux_sel) != 3'b010) |-> $past(rdy_ext));

    assert_pll_ready_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mux_sel == 3'b100 && $past(mux_sel) != 3'b100) |-> $past(rdy_pll));

    assert_fallback_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (css_en && ext_fail && (mux_sel == 3'b010 || (mux_sel == 3'b100 && pll_ref_ext)))
        |=> (mux_sel == 3'b001));

    assert_wake_int_R11: assert property (@(posedge clk) disable iff (!rst_n)
        wake |=> (mux_sel == 3'b001));
endmodule

bind sysclk_source_ctrl sysclk_source_ctrl_chk #(
    .STAT_W   (STAT_W),
    .FIELD_LSB(FIELD_LSB)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rdy_ext    (rdy_ext),
    .rdy_pll    (rdy_pll),
    .pll_ref_ext(pll_ref_ext),
    .css_en     (css_en),
    .ext_fail   (ext_fail),
    .wake       (wake),
    .mux_sel    (mux_sel),
    .status     (status)
);

// File: tb/sysclk_source_ctrl_test.sv
`timescale 1ns/1ps
module sysclk_source_ctrl_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_we = 1'b0;
    logic [1:0] req_code = 2'd0;
    logic       rdy_int = 1'b1, rdy_ext = 1'b0, rdy_pll = 1'b0;
    logic       pll_ref_ext = 1'b0, css_en = 1'b0, ext_fail = 1'b0, wake = 1'b0;
    logic [2:0] mux_sel;
    logic [3:0] status;

    int  n_run = 0, n_fail = 0;
    bit  done = 1'b0;

    // bench model state
    logic [1:0] m_act = 2'd0, m_pend = 2'd0;
    bit         m_pv = 1'b0, m_lock = 1'b0;

    always #4 clk = ~clk;

    sysclk_source_ctrl uut (
        .clk(clk), .rst_n(rst_n), .req_we(req_we), .req_code(req_code),
        .rdy_int(rdy_int), .rdy_ext(rdy_ext), .rdy_pll(rdy_pll),
        .pll_ref_ext(pll_ref_ext), .css_en(css_en), .ext_fail(ext_fail),
        .wake(wake), .mux_sel(mux_sel), .status(status)
    );

    function automatic logic [2:0] exp_sel(input logic [1:0] a);
        return 3'b001 << a;
    endfunction

    function automatic logic [3:0] exp_stat(input logic [1:0] a);
        return {a, 2'b00};
    endfunction

    function automatic bit barred(input logic [1:0] c, input bit lk, input bit ref_ext);
        if (c == 2'd3) return 1'b1;
        if (c == 2'd1) return lk;
        if (c == 2'd2) return lk && ref_ext;
        return 1'b0;
    endfunction

    function automatic bit is_ready(input logic [1:0] c);
        case (c)
            2'd0:    return rdy_int;
            2'd1:    return rdy_ext;
            2'd2:    return rdy_pll;
            default: return 1'b0;
        endcase
    endfunction

    task automatic model_step();
        bit frc, lk_n;
        frc  = css_en && ext_fail && (m_act == 2'd1 || (m_act == 2'd2 && pll_ref_ext));
        lk_n = ext_fail && (m_lock || frc);
        if (wake || frc) begin
            m_act = 2'd0;
            m_pv  = 1'b0;
        end else begin
            if (req_we && !barred(req_code, m_lock, pll_ref_ext)) begin
                if (req_code == m_act) m_pv = 1'b0;
                else begin m_pv = 1'b1; m_pend = req_code; end
            end
            if (m_pv && is_ready(m_pend) && !barred(m_pend, m_lock, pll_ref_ext)) begin
                m_act = m_pend;
                m_pv  = 1'b0;
            end
        end
        m_lock = lk_n;
    endtask

    task automatic check(input string tag, input logic [3:0] got, input logic [3:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic tick(input string tag);
        model_step();
        @(posedge clk);
        #1;
        check(tag, {1'b0, mux_sel}, {1'b0, exp_sel(m_act)});
        check("R8", status, exp_stat(m_act));
        req_we = 1'b0;
        wake   = 1'b0;
    endtask

    task automatic request(input logic [1:0] c);
        req_we   = 1'b1;
        req_code = c;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_C10C));
        repeat (3) @(posedge clk);
        #1;
        check("R1", {1'b0, mux_sel}, 4'b0001);
        check("R1", status, 4'b0000);
        rst_n = 1'b1;
        tick("R1");

        // R3: ready target switches at the strobe edge
        rdy_ext = 1'b1; request(2'd1); tick("R3");
        check("R3", {1'b0, mux_sel}, 4'b0010);

        // R4: PLL not ready, held until lock
        request(2'd2); tick("R4");
        tick("R4"); tick("R4");
        check("R4", {1'b0, mux_sel}, 4'b0010);
        rdy_pll = 1'b1; tick("R4");
        check("R4", {1'b0, mux_sel}, 4'b0100);

        // R5: later request replaces earlier pending one
        rdy_ext = 1'b0; rdy_pll = 1'b0; rdy_int = 1'b0;
        request(2'd1); tick("R5");
        request(2'd0); tick("R5");
        rdy_ext = 1'b1; tick("R5"); tick("R5");
        check("R5", {1'b0, mux_sel}, 4'b0100);
        rdy_int = 1'b1; tick("R5");
        check("R5", {1'b0, mux_sel}, 4'b0001);

        // R6: requesting the active source cancels pending
        rdy_ext = 1'b0;
        request(2'd1); tick("R6");
        request(2'd0); tick("R6");
        rdy_ext = 1'b1; tick("R6"); tick("R6");
        check("R6", {1'b0, mux_sel}, 4'b0001);

        // R7: code 11 ignored, pending kept
        rdy_ext = 1'b0; request(2'd3); tick("R7");
        check("R7", {1'b0, mux_sel}, 4'b0001);
        request(2'd1); tick("R7");
        request(2'd3); tick("R7");
        rdy_ext = 1'b1; tick("R7");
        check("R7", {1'b0, mux_sel}, 4'b0010);

        // R9: failure ignored without security, fallback with it
        ext_fail = 1'b1; tick("R9");
        check("R9", {1'b0, mux_sel}, 4'b0010);
        css_en = 1'b1; tick("R9");
        check("R9", {1'b0, mux_sel}, 4'b0001);

        // R10: lockout until failure flag clears
        request(2'd1); tick("R10"); tick("R10");
        check("R10", {1'b0, mux_sel}, 4'b0001);
        ext_fail = 1'b0; tick("R10");
        request(2'd1); tick("R10");
        check("R10", {1'b0, mux_sel}, 4'b0010);

        // R9: PLL fed by external oscillator also falls back
        pll_ref_ext = 1'b1; rdy_pll = 1'b1; request(2'd2); tick("R9");
        check("R9", {1'b0, mux_sel}, 4'b0100);
        ext_fail = 1'b1; tick("R9");
        check("R9", {1'b0, mux_sel}, 4'b0001);
        ext_fail = 1'b0; tick("R10");

        // R11: wake forces internal and wins over a same-cycle request
        request(2'd2); tick("R11");
        check("R11", {1'b0, mux_sel}, 4'b0100);
        wake = 1'b1; request(2'd1); tick("R11");
        check("R11", {1'b0, mux_sel}, 4'b0001);
        tick("R11"); tick("R11");
        check("R11", {1'b0, mux_sel}, 4'b0001);

        // R2: constrained random mix
        for (int i = 0; i < 4000; i++) begin
            if ($urandom % 10 == 0) rdy_int = ~rdy_int;
            if ($urandom % 8 == 0)  rdy_ext = ~rdy_ext;
            if ($urandom % 8 == 0)  rdy_pll = ~rdy_pll;
            if ($urandom % 50 == 0) pll_ref_ext = ~pll_ref_ext;
            if ($urandom % 30 == 0) ext_fail = ~ext_fail;
            css_en = ($urandom % 10 != 0);
            if ($urandom % 4 == 0) request(2'($urandom % 4));
            if ($urandom % 60 == 0) wake = 1'b1;
            tick("R2");
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule